// File: doc/BRIEF.md
# Floating-Point Exception Mask and Flag Unit

This block holds the exception side of a floating-point unit's control and status state. It keeps a 16-bit control word whose low six bits mask six kinds of numeric exception and whose bits 11 to 10 select the rounding method. It collects single-cycle pulses for invalid operation, denormal operand, zero divide, overflow, underflow and inexact result into sticky flags. It also records stack faults, which count as invalid operations.

A flag whose mask bit is set is only recorded: the unit resolves it internally and asks for nothing. A flag whose mask bit is clear makes the interrupt-request bit of the status word high. The unit then gives a one-cycle handler request as that bit rises. The request stays high until software issues the clear strobe or an init. Changing the masks acts at once on flags that are already pending. The numeric results and the handler itself belong to other blocks.

Top module: `fpx_exc_ctl`

## Requirements
- R1: After reset or an init strobe, `cw_o` is 0x037F, `sw_exc_o` is 0x00, `ir_o` and `handler_req_o` are 0, and `rc_o` is 0 (nearest).
- R2: A pulse on `exc_i[k]` sets status flag `sw_exc_o[k]` in the cycle after the pulse. The positions are bit 0 invalid, bit 1 denormal, bit 2 zero divide, bit 3 overflow, bit 4 underflow and bit 5 inexact. A set flag stays set until the clear strobe or init.
- R3: Control-word bits 5 to 0 mask the exception at the same bit position. An exception whose mask bit is 1 sets its flag but leaves `ir_o` at 0 and raises no handler request.
- R4: `ir_o` and `sw_exc_o[7]` are 1 whenever any flag is set with its mask bit at 0. `handler_req_o` is 1 for exactly the one cycle in which `ir_o` goes from 0 to 1, and later exceptions while `ir_o` is already 1 give no further request.
- R5: A pulse on `stk_fault_i` sets `sw_exc_o[6]` and the invalid flag `sw_exc_o[0]` in the next cycle.
- R6: A clear strobe zeroes `sw_exc_o[7:0]`, and with it `ir_o`, in the next cycle. It takes priority over exception and stack-fault pulses in the same cycle.
- R7: A control-word write loads `cw_data_i` into `cw_o` in the next cycle. If the write unmasks a flag that is already set, `ir_o` is 1 in that same next cycle. If it masks all pending flags, `ir_o` drops while the flags stay.
- R8: `rc_o` equals control-word bits 11 to 10, with 0 for nearest-even, 1 for toward minus infinity, 2 for toward plus infinity and 3 for toward zero.
- R9: An init strobe takes priority over a control-word write, a clear and any exception pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Init strobe, restores the reset images |
| cw_wr_i | input | 1 | Control-word write strobe |
| cw_data_i | input | 16 | Control-word write data |
| exc_i | input | 6 | Exception pulses, one bit per kind |
| stk_fault_i | input | 1 | Stack-fault pulse |
| clr_i | input | 1 | Clear-exceptions strobe |
| cw_o | output | 16 | Current control word |
| rc_o | output | 2 | Rounding-control field |
| sw_exc_o | output | 8 | Status bits: 7 request, 6 stack fault, 5..0 flags |
| ir_o | output | 1 | Interrupt request, any unmasked flag pending |
| handler_req_o | output | 1 | One-cycle handler request on the rise of `ir_o` |

## Verification
The properties assume that every strobe and pulse is synchronous to `clk`. They also assume that init and clear are applied as single-cycle strobes whose priority over other inputs in the same cycle follows R6 and R9. The bench drives all inputs one time unit after a rising edge and holds each for exactly one cycle. It sweeps every mask value against every exception pattern. It also combines init, clear, write and pulses in the same cycle, so the priority cases are exercised without breaking those assumptions.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_N = 6;
    localparam int CW_W = 16;
    localparam int SW_EXC_W = EXC_N + 2;
    localparam int RC_LSB = 10;
    localparam logic [CW_W-1:0] CW_RESET = 16'h037F;

    typedef enum logic [1:0] {
        RC_NEAREST = 2'd0,
        RC_DOWN    = 2'd1,
        RC_UP      = 2'd2,
        RC_TRUNC   = 2'd3
    } rc_e;

    typedef struct packed {
        logic             ir;
        logic             sf;
        logic [EXC_N-1:0] flg;
    } exc_state_t;

    function automatic rc_e rc_field(input logic [CW_W-1:0] cw);
        return rc_e'(cw[RC_LSB +: 2]);
    endfunction

    function automatic logic pending_unmasked(input logic [EXC_N-1:0] flg,
                                              input logic [EXC_N-1:0] msk);
        return |(flg & ~msk);
    endfunction
endpackage

// File: rtl/fpx_cw_reg.sv
module fpx_cw_reg
    import fpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            init_i,
    input  logic            wr_i,
    input  logic [CW_W-1:0] data_i,
    output logic [CW_W-1:0] cw_o
);
    always_ff @(posedge clk) begin
        if (rst || init_i)
            cw_o <= CW_RESET;
        else if (wr_i)
            cw_o <= data_i;
    end
endmodule

// File: rtl/fpx_flag_acc.sv
module fpx_flag_acc
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic             clr_i,
    input  logic [EXC_N-1:0] exc_i,
    input  logic             sf_i,
    output logic [EXC_N-1:0] flg_o,
    output logic             sf_o
);
    localparam int INV_BIT = 0;

    logic [EXC_N-1:0] hit;

    always_comb begin
        hit = exc_i;
        hit[INV_BIT] = exc_i[INV_BIT] | sf_i;
    end

    always_ff @(posedge clk) begin
        if (rst || init_i || clr_i) begin
            flg_o <= '0;
            sf_o  <= 1'b0;
        end else begin
            flg_o <= flg_o | hit;
            sf_o  <= sf_o | sf_i;
        end
    end
endmodule

// File: rtl/fpx_irq_gen.sv
module fpx_irq_gen
    import fpx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_i,
    input  logic [EXC_N-1:0] flg_i,
    input  logic [EXC_N-1:0] msk_i,
    output logic             ir_o,
    output logic             req_o
);
    logic ir_prev_q;

    assign ir_o  = pending_unmasked(flg_i, msk_i);
    assign req_o = ir_o & ~ir_prev_q;

    always_ff @(posedge clk) begin
        if (rst || init_i)
            ir_prev_q <= 1'b0;
        else
            ir_prev_q <= ir_o;
    end
endmodule

// File: rtl/fpx_exc_ctl.sv
module fpx_exc_ctl
    import fpx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         cw_wr_i,
    input  logic [15:0]  cw_data_i,
    input  logic [5:0]   exc_i,
    input  logic         stk_fault_i,
    input  logic         clr_i,
    output logic [15:0]  cw_o,
    output logic [1:0]   rc_o,
    output logic [7:0]   sw_exc_o,
    output logic         ir_o,
    output logic         handler_req_o
);
    logic [CW_W-1:0]  cw;
    logic [EXC_N-1:0] flg;
    logic             sf;
    logic             ir;
    exc_state_t       st;

    fpx_cw_reg u_cw (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_i),
        .wr_i   (cw_wr_i),
        .data_i (cw_data_i),
        .cw_o   (cw)
    );

    fpx_flag_acc u_flags (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_i),
        .clr_i  (clr_i),
        .exc_i  (exc_i),
        .sf_i   (stk_fault_i),
        .flg_o  (flg),
        .sf_o   (sf)
    );

    fpx_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_i),
        .flg_i  (flg),
        .msk_i  (cw[EXC_N-1:0]),
        .ir_o   (ir),
        .req_o  (handler_req_o)
    );

    always_comb begin
        st.ir  = ir;
        st.sf  = sf;
        st.flg = flg;
    end

    assign cw_o     = cw;
    assign rc_o     = rc_field(cw);
    assign sw_exc_o = st;
    assign ir_o     = ir;
endmodule

// File: rtl/fpx_exc_ctl_chk.sv
module fpx_exc_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        init_i,
    input logic        cw_wr_i,
    input logic [15:0] cw_data_i,
    input logic [5:0]  exc_i,
    input logic        stk_fault_i,
    input logic        clr_i,
    input logic [15:0] cw_o,
    input logic [7:0]  sw_exc_o,
    input logic        ir_o,
    input logic        handler_req_o
);
    assert_init_image_R1: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (cw_o == 16'h037F) && (sw_exc_o == 8'h00));

    assert_flags_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !clr_i) |=> (($past(sw_exc_o[5:0]) & ~sw_exc_o[5:0]) == 6'h00));

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (!cw_wr_i && !ir_o && ((exc_i & ~cw_o[5:0]) == 6'h00)
         && !(stk_fault_i && !cw_o[0])) |=> !ir_o);

    assert_req_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        handler_req_o |-> ir_o && sw_exc_o[7]);

    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
        handler_req_o |=> !handler_req_o);

    assert_stack_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (stk_fault_i && !clr_i && !init_i) |=> sw_exc_o[6] && sw_exc_o[0]);

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !init_i) |=> (sw_exc_o == 8'h00) && !ir_o);

    assert_cw_write_R7: assert property (@(posedge clk) disable iff (rst)
        (cw_wr_i && !init_i) |=> cw_o == $past(cw_data_i));
endmodule

bind fpx_exc_ctl fpx_exc_ctl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .init_i        (init_i),
    .cw_wr_i       (cw_wr_i),
    .cw_data_i     (cw_data_i),
    .exc_i         (exc_i),
    .stk_fault_i   (stk_fault_i),
    .clr_i         (clr_i),
    .cw_o          (cw_o),
    .sw_exc_o      (sw_exc_o),
    .ir_o          (ir_o),
    .handler_req_o (handler_req_o)
);

// File: tb/fpx_exc_ctl_bench.sv
`timescale 1ns/1ps
module fpx_exc_ctl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_i = 1'b0;
    logic        cw_wr_i = 1'b0;
    logic [15:0] cw_data_i = '0;
    logic [5:0]  exc_i = '0;
    logic        stk_fault_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [15:0] cw_o;
    logic [1:0]  rc_o;
    logic [7:0]  sw_exc_o;
    logic        ir_o;
    logic        handler_req_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fpx_exc_ctl u_fpx_exc_ctl (
        .clk(clk), .rst(rst), .init_i(init_i), .cw_wr_i(cw_wr_i),
        .cw_data_i(cw_data_i), .exc_i(exc_i), .stk_fault_i(stk_fault_i),
        .clr_i(clr_i), .cw_o(cw_o), .rc_o(rc_o), .sw_exc_o(sw_exc_o),
        .ir_o(ir_o), .handler_req_o(handler_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        init_i = 1'b0; cw_wr_i = 1'b0; exc_i = '0; stk_fault_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic write_cw(input logic [15:0] v);
        cw_wr_i = 1'b1; cw_data_i = v;
        tick();
    endtask

    task automatic check_idle(input string req);
        check(req, {16'h0, cw_o}, 32'h037F);
        check(req, {24'h0, sw_exc_o}, 32'h0);
        check(req, {30'h0, rc_o}, 32'h0);
        check(req, {31'h0, ir_o}, 32'h0);
        check(req, {31'h0, handler_req_o}, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        check_idle("R1 reset");

        // R2/R3/R4 sweep of every mask against every exception pattern
        for (int m = 0; m < 64; m++) begin
            for (int p = 0; p < 64; p++) begin
                logic exp_ir;
                exp_ir = |(6'(p) & ~6'(m));
                write_cw(16'h0340 | 16'(m));
                check("R7 write", {16'h0, cw_o}, 32'h0340 | m);
                exc_i = 6'(p);
                tick();
                check("R2 flags", {26'h0, sw_exc_o[5:0]}, 32'(p));
                check("R3/R4 ir", {30'h0, sw_exc_o[7], ir_o}, {30'h0, exp_ir, exp_ir});
                check("R4 req rise", {31'h0, handler_req_o}, {31'h0, exp_ir});
                tick();
                check("R2 sticky", {24'h0, sw_exc_o}, {24'h0, exp_ir, 1'b0, 6'(p)});
                check("R4 req single", {31'h0, handler_req_o}, 32'h0);
                clr_i = 1'b1;
                tick();
                check("R6 clear", {23'h0, ir_o, sw_exc_o}, 32'h0);
            end
        end

        // R4: second exception while pending gives no new request
        write_cw(16'h0340);
        exc_i = 6'b000100; tick();
        check("R4 first req", {31'h0, handler_req_o}, 32'h1);
        exc_i = 6'b001000; tick();
        check("R4 no second req", {31'h0, handler_req_o}, 32'h0);
        check("R4 ir held", {31'h0, ir_o}, 32'h1);
        check("R2 both flags", {26'h0, sw_exc_o[5:0]}, 32'h0C);

        // R6: clear beats same-cycle pulses
        clr_i = 1'b1; exc_i = 6'h3F; stk_fault_i = 1'b1; tick();
        check("R6 clear priority", {23'h0, ir_o, sw_exc_o}, 32'h0);

        // R5: stack fault, masked invalid
        write_cw(16'h037F);
        stk_fault_i = 1'b1; tick();
        check("R5 sf+invalid", {24'h0, sw_exc_o}, 32'h41);
        check("R5 masked no ir", {31'h0, ir_o}, 32'h0);

        // R7: unmask pending invalid raises ir immediately, remask drops it
        write_cw(16'h037E);
        check("R7 unmask ir", {31'h0, ir_o}, 32'h1);
        check("R7 unmask req", {31'h0, handler_req_o}, 32'h1);
        write_cw(16'h037F);
        check("R7 remask ir", {31'h0, ir_o}, 32'h0);
        check("R7 flags kept", {24'h0, sw_exc_o}, 32'h41);

        // R8: rounding field
        for (int r = 0; r < 4; r++) begin
            write_cw(16'h003F | 16'(r << 10));
            check("R8 rc", {30'h0, rc_o}, 32'(r));
        end

        // R9: init beats write, clear and pulses
        write_cw(16'h0000);
        exc_i = 6'h01; tick();
        init_i = 1'b1; cw_wr_i = 1'b1; cw_data_i = 16'h0C00; exc_i = 6'h3F;
        stk_fault_i = 1'b1; clr_i = 1'b1;
        tick();
        check_idle("R9 init priority");
        check_idle("R1 init image");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule